// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Vector Readout

This block gathers a set of level-sensitive interrupt request lines into a source register, one bit per line, refreshed on every clock. A software-written enable mask qualifies the source bits; the qualified set is called pending. A single combined interrupt output is raised whenever any pending bit is set, so one upstream interrupt pin can stand for many devices.

Software reaches the block through a small 16-bit register port with two locations. The vector location is read only. It does not return a bitmap: it returns a small code naming the lowest-numbered pending line, which a handler can use directly as a table offset. The mask location is readable and writable. Every other location reads as zero and ignores writes. Reads are combinational from the current register state. A write lands on the next rising clock edge.

Top module: `irq_vector_agg`

## Requirements
- R1: Each source bit takes the level of its request input at every rising clock edge: set while the line is high, cleared while it is low.
- R2: The combined output `irqOut` is registered and, one clock after any input or mask change, is high exactly when source AND mask is nonzero.
- R3: A read at byte offset 0 returns ((n + 1) << 2), where n is the lowest-numbered bit that is set in both source and mask. Line 0 reads as 4 and line 15 reads as 64.
- R4: A read at offset 0 returns 0 when no bit is pending.
- R5: A write at offset 2 loads the mask from the low 16 data bits at the next edge. A read at offset 2 returns the mask. The new mask governs `irqOut` from that same edge.
- R6: During and right after reset, the mask is 0x0010, the source is all zero and `irqOut` is low.
- R7: Reads at any offset other than 0 and 2 return 0. Writes there change neither the mask nor the output.
- R8: A write at offset 0 is ignored: the mask and the vector are unchanged.
- R9: A line whose mask bit is clear never appears in the vector, even when it is the lowest active request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 16 | Level-sensitive request lines |
| regAddr | input | 12 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe for the access at regAddr |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Combinational read data for regAddr |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
The hardest case to reach is a request and a mask write that change in the same clock. In that cycle the output must already follow the new mask, not the old one. Random steps often drive a fresh request pattern together with a mask write, and a directed step lowers the mask to exactly cover a line that just went high. A second hard case is the vector's lowest-index choice when a lower line is active but masked. Directed patterns set a masked lower line alongside an enabled higher one, and they place a single pending line at each end of the range.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Strobes from the address decoder to the datapath
  typedef struct packed {
    logic selVec;   // access addresses the vector location
    logic selMask;  // access addresses the mask location
    logic wrMask;   // load the mask at the next edge
  } regStrobe_t;
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int VEC_OFS  = 0,
  parameter int MASK_OFS = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-1:0] VecAddr  = ADDR_W'(VEC_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr = ADDR_W'(MASK_OFS);

  always_comb begin
    strb.selVec  = (regAddr == VecAddr);
    strb.selMask = (regAddr == MaskAddr);
    strb.wrMask  = regWrEn && (regAddr == MaskAddr);
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 16,
  parameter logic [NUM_LINES-1:0] MASK_RST = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic [DATA_W-1:0]    regWrData,
  input  regStrobe_t           strb,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irqOut,
  output logic [NUM_LINES-1:0] srcQ,
  output logic [NUM_LINES-1:0] maskQ
);
  localparam int VecShift = 2;

  logic [NUM_LINES-1:0] maskNext;
  logic [NUM_LINES-1:0] pending;
  logic [DATA_W-1:0]    vecVal;

  // Per-line source flops follow the request level
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) srcQ[g] <= 1'b0;
      else       srcQ[g] <= irqReq[g];
    end
  end

  always_comb begin
    maskNext = strb.wrMask ? regWrData[NUM_LINES-1:0] : maskQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= MASK_RST;
      irqOut <= 1'b0;
    end else begin
      maskQ  <= maskNext;
      // Same edge as srcQ/maskQ load, so output tracks the new state
      irqOut <= |(irqReq & maskNext);
    end
  end

  assign pending = srcQ & maskQ;

  // Lowest pending index wins: scan downward so lower indices overwrite
  always_comb begin
    vecVal = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pending[i]) vecVal = DATA_W'((i + 1) << VecShift);
    end
  end

  always_comb begin
    if (strb.selVec)       regRdData = vecVal;
    else if (strb.selMask) regRdData = DATA_W'(maskQ);
    else                   regRdData = '0;
  end
endmodule

// File: rtl/irq_vector_agg.sv
module irq_vector_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 12,
  parameter logic [NUM_LINES-1:0] MASK_RST = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irqOut
);
  regStrobe_t           strb;
  logic [NUM_LINES-1:0] srcQ;
  logic [NUM_LINES-1:0] maskQ;

  irq_agg_ctrl #(.ADDR_W(ADDR_W), .VEC_OFS(0), .MASK_OFS(2)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  irq_agg_dp #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .MASK_RST(MASK_RST)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqReq    (irqReq),
    .regWrData (regWrData),
    .strb      (strb),
    .regRdData (regRdData),
    .irqOut    (irqOut),
    .srcQ      (srcQ),
    .maskQ     (maskQ)
  );
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqReq,
  input logic [ADDR_W-1:0]    regAddr,
  input logic                 regWrEn,
  input logic [DATA_W-1:0]    regWrData,
  input logic [DATA_W-1:0]    regRdData,
  input logic                 irqOut,
  input logic [NUM_LINES-1:0] srcQ,
  input logic [NUM_LINES-1:0] maskQ
);
  localparam logic [ADDR_W-1:0] VecA  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MaskA = ADDR_W'(2);

  p_src_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    srcQ == $past(irqReq));

  p_out_pending_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(srcQ & maskQ));

  p_vec_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == VecA) |-> (regRdData[1:0] == 2'b00));

  p_vec_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == VecA && (srcQ & maskQ) == '0) |-> (regRdData == '0));

  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == MaskA) |=> (maskQ == $past(regWrData[NUM_LINES-1:0])));

  p_other_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != VecA && regAddr != MaskA) |-> (regRdData == '0));

  p_no_stray_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != MaskA) |=> $stable(maskQ));
endmodule

bind irq_vector_agg irq_agg_chk #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqReq    (irqReq),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqOut    (irqOut),
  .srcQ      (srcQ),
  .maskQ     (maskQ)
);

// File: tb/irq_vector_agg_tb.sv
module irq_vector_agg_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] irqReq;
  logic [11:0] regAddr;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] expSrc;
  logic [15:0] expMask;

  always #10 clk = ~clk;  // 50 MHz

  irq_vector_agg u_dut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic logic [15:0] expVec(input logic [15:0] s, input logic [15:0] m);
    logic [15:0] p;
    p = s & m;
    for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) * 4);
    return 16'd0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock step: drive at negedge, next negedge update model, check output
  task automatic step(input logic [15:0] req, input logic wr, input logic [11:0] a,
                      input logic [15:0] d);
    @(negedge clk);
    irqReq = req; regWrEn = wr; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    expSrc = req;
    if (wr && a == 12'd2) expMask = d;
    check("R2 irqOut", {15'd0, irqOut}, {15'd0, |(expSrc & expMask)});
  endtask

  task automatic readAt(input string req, input logic [11:0] a, input logic [15:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic readBoth();
    readAt("R3 R1 vector", 12'd0, expVec(expSrc, expMask));
    readAt("R5 mask read", 12'd2, expMask);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; irqReq = '0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    expSrc = '0; expMask = 16'h0010;
    repeat (3) @(negedge clk);
    // R6: reset state, held request lines high to prove source cleared
    irqReq = 16'hffff;
    @(negedge clk);
    check("R6 irqOut in reset", {15'd0, irqOut}, 16'd0);
    readAt("R6 mask reset", 12'd2, 16'h0010);
    readAt("R6 vector reset", 12'd0, 16'd0);
    irqReq = '0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 irqOut after reset", {15'd0, irqOut}, 16'd0);

    // R1/R3: default mask enables line 4 -> vector 20
    step(16'h0010, 1'b0, 12'd0, 16'd0); readBoth();
    check("R3 line4 vector", expVec(expSrc, expMask), 16'd20);
    // R1: line drops, source clears
    step(16'h0000, 1'b0, 12'd0, 16'd0); readBoth();
    // R4: active but masked line -> zero vector, output low
    step(16'h0001, 1'b0, 12'd0, 16'd0);
    readAt("R4 no pending vector", 12'd0, 16'd0);
    // R5: same-cycle mask write covering that line
    step(16'h0001, 1'b1, 12'd2, 16'h0001); readBoth();
    readAt("R3 line0 is 4", 12'd0, 16'd4);
    // R3: highest line only
    step(16'h8000, 1'b1, 12'd2, 16'hffff);
    readAt("R3 line15 is 64", 12'd0, 16'd64);
    // R9: lower line active but masked, higher enabled
    step(16'h0104, 1'b1, 12'd2, 16'h0100);
    readAt("R9 masked lower line", 12'd0, 16'd36);
    // R8: write to vector offset ignored
    step(16'h0104, 1'b1, 12'd0, 16'hffff);
    readAt("R8 mask after vec write", 12'd2, 16'h0100);
    readAt("R8 vector after vec write", 12'd0, 16'd36);
    // R7: stray offsets read zero, writes ignored
    step(16'h0104, 1'b1, 12'd6, 16'h0004);
    readAt("R7 mask after stray write", 12'd2, 16'h0100);
    step(16'h0104, 1'b1, 12'd3, 16'h0004);
    readAt("R7 mask after odd write", 12'd2, 16'h0100);
    readAt("R7 read offset 4", 12'd4, 16'd0);
    readAt("R7 read offset 0xfff", 12'hfff, 16'd0);
    // R2: clear mask drops output next clock
    step(16'h0104, 1'b1, 12'd2, 16'h0000); readBoth();

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] rq;
      logic        wr;
      logic [11:0] a;
      logic [15:0] d;
      rq = 16'($urandom);
      if ($urandom_range(0, 1) == 0) rq = rq & 16'($urandom);
      wr = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 3))
        0: a = 12'd0;
        1: a = 12'($urandom);
        default: a = 12'd2;
      endcase
      d = 16'($urandom);
      if ($urandom_range(0, 1) == 0) d = 16'(1) << $urandom_range(0, 15);
      step(rq, wr, a, d);
      readBoth();
      readAt("R7 random stray read", 12'd8, 16'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule